// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block takes an Ethernet transceiver from power-on to a known link state without any software help. It first drives the transceiver's hardware reset pin low for a programmable time and then releases it. It then probes every management address from 0 upward, reading the control register at each one, and takes the first address whose reset bit reads back clear as the location of the PHY. Next it reads the status register. A link that is already up ends the run at once with success. A link that is down makes the block request a soft reset, wait until the PHY reports the reset as complete, restart auto-negotiation with full duplex advertised, and poll the link bit at a fixed interval until the link comes up or the poll budget runs out.

Every register access goes through an abstract management access port; the serial management framing itself lies outside this block. The block holds `mdio_req` high with stable command fields until the responder pulses `mdio_done` for one cycle, and on that cycle `mdio_rdata` carries the read result. After each `mdio_done` the block keeps `mdio_req` low for at least one cycle, so only one access is ever outstanding. The responder applies back-pressure by holding off `mdio_done` for as long as it needs. The run starts by itself when `rst_n` is released. While `done` is high, a one-cycle `start` pulse runs the whole sequence again.

All waits are counted in system clock cycles. `RST_CYCLES` sets the reset pulse length, `POLL_GAP_CYCLES` the pause between link polls, `POLL_LIMIT` the maximum number of link polls and `RESET_TRIES` the maximum number of soft-reset status reads.

Top module: `phy_bringup`

## Requirements
- R1: After `rst_n` is released, `phy_rst_n` stays low for exactly `RST_CYCLES` clock cycles. After a restart it stays low for `RST_CYCLES` + 1 cycles. `mdio_req` is never high while `phy_rst_n` is low.
- R2: The scan is a series of reads of register 0, at addresses 0, 1, 2 and so on, in rising order. It stops at the first address whose read data has bit 15 equal to 0, and `phy_addr` then holds that address.
- R3: If all 32 scan reads return bit 15 equal to 1, the block raises `err_no_phy` and `done` and makes no further access.
- R4: After a successful scan, the block reads register 1 at the found address. If bit 2 (link) is 1, it raises `link_up` and `done` and performs no write.
- R5: If the link bit is 0, the block writes 16'h8000 to register 0. It then reads register 0 until bit 15 reads 0, making at most `RESET_TRIES` such reads. If all of them return bit 15 equal to 1, it raises `err_reset` and `done` and writes nothing more.
- R6: Once the soft reset has cleared, the block writes 16'h1300 to register 0. This sets the restart, auto-negotiation enable and full-duplex bits. No other value or register is ever written.
- R7: After the 16'h1300 write, the block reads register 1 at most `POLL_LIMIT` times, with at least `POLL_GAP_CYCLES` cycles between the completion of one poll and the request for the next. A poll with bit 2 equal to 1 raises `link_up`. If every poll returns bit 2 equal to 0, the block raises `warn_link_timeout`.
- R8: Access fields stay stable while `mdio_req` is high and `mdio_done` has not arrived, and `mdio_req` is low in the cycle after `mdio_done`. Every access after the scan targets `phy_addr`.
- R9: While `done` is high, exactly one of `link_up`, `err_no_phy`, `err_reset` and `warn_link_timeout` is set, and the outputs hold until the next `start`. A `start` seen while `done` is high clears them and restarts from the hardware reset. A `start` seen while the block is busy is ignored.
- R10: While `rst_n` is low, `done`, all four flags, `mdio_req` and `phy_addr` are 0, and `phy_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Re-run request, accepted while `done` is high |
| phy_rst_n | output | 1 | Active-low hardware reset to the transceiver |
| mdio_req | output | 1 | Access request, held high until `mdio_done` |
| mdio_we | output | 1 | 1 for a write access, 0 for a read access |
| mdio_addr | output | 5 | Management address of the access |
| mdio_reg | output | 5 | Register number of the access |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | One-cycle completion pulse from the responder |
| mdio_rdata | input | 16 | Read data, valid while `mdio_done` is high |
| phy_addr | output | 5 | Address the scan found |
| done | output | 1 | Sequence finished |
| link_up | output | 1 | Finished with the link up |
| err_no_phy | output | 1 | No address answered with reset clear |
| err_reset | output | 1 | Soft reset never cleared |
| warn_link_timeout | output | 1 | Link still down after the last poll |

## Verification
The bench builds the block with an 8-cycle hardware reset, a 4-cycle poll gap, a budget of 5 polls and the full 10 soft-reset reads. With these values every outcome completes within a few hundred cycles. That makes a complete sweep practical. It places the PHY at each of the 32 addresses and also leaves it absent. It varies the number of busy soft-reset reads from 0 up to and including the limit, and the number of polls until link from 1 to one beyond the budget. For each case the bench's model of the responder works out the expected access trace and the expected final flag. A start pulse sent while the block is busy, and the two lengths of the reset pulse, are also checked.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  typedef enum logic [3:0] {
    S_HWRST,
    S_SCAN,
    S_STAT,
    S_SRST_WR,
    S_SRST_RD,
    S_AN_WR,
    S_POLL_RD,
    S_POLL_WAIT,
    S_DONE
  } bring_state_t;

  typedef struct packed {
    logic link_up;
    logic no_phy;
    logic rst_fail;
    logic timeout;
  } bring_flags_t;

  localparam logic [4:0]  REG_CTRL = 5'd0;
  localparam logic [4:0]  REG_STAT = 5'd1;
  localparam int          BIT_RST  = 15;
  localparam int          BIT_LINK = 2;
  localparam logic [15:0] CMD_SRST = 16'h8000;
  localparam logic [15:0] CMD_AUTO = 16'h1300;

endpackage

// File: rtl/phy_bringup_timer.sv
module phy_bringup_timer #(
  parameter int           W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= INIT;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/phy_bringup_ctrl.sv
module phy_bringup_ctrl
  import phy_bringup_pkg::*;
#(
  parameter int ADDR_W          = 5,
  parameter int TMR_W           = 8,
  parameter int RST_CYCLES      = 8,
  parameter int POLL_GAP_CYCLES = 4,
  parameter int POLL_LIMIT      = 5,
  parameter int RESET_TRIES     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [4:0]        regn,
  output logic [15:0]       wdata,
  input  logic              acc_done,
  input  logic [15:0]       rdata,
  output logic              phy_rst_n,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              done,
  output bring_flags_t      flags
);

  localparam int TRY_W  = $clog2(RESET_TRIES + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [TRY_W-1:0]  LAST_TRY  = TRY_W'(RESET_TRIES - 1);
  localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(POLL_LIMIT - 1);

  bring_state_t      state;
  logic [ADDR_W-1:0] scan_addr;
  logic [TRY_W-1:0]  tries;
  logic [POLL_W-1:0] polls;
  logic              gap;
  logic              rd_rst, rd_link, is_access;

  assign rd_rst  = rdata[BIT_RST];
  assign rd_link = rdata[BIT_LINK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_HWRST;
      scan_addr <= '0;
      tries     <= '0;
      polls     <= '0;
      gap       <= 1'b0;
      flags     <= '0;
      phy_addr  <= '0;
    end else begin
      gap <= acc_done;
      case (state)
        S_HWRST: if (tmr_zero) begin
          scan_addr <= '0;
          state     <= S_SCAN;
        end
        S_SCAN: if (acc_done) begin
          if (!rd_rst) begin
            phy_addr <= scan_addr;
            state    <= S_STAT;
          end else if (scan_addr == LAST_ADDR) begin
            flags.no_phy <= 1'b1;
            state        <= S_DONE;
          end else begin
            scan_addr <= scan_addr + 1'b1;
          end
        end
        S_STAT: if (acc_done) begin
          if (rd_link) begin
            flags.link_up <= 1'b1;
            state         <= S_DONE;
          end else begin
            state <= S_SRST_WR;
          end
        end
        S_SRST_WR: if (acc_done) begin
          tries <= '0;
          state <= S_SRST_RD;
        end
        S_SRST_RD: if (acc_done) begin
          if (!rd_rst) begin
            state <= S_AN_WR;
          end else if (tries == LAST_TRY) begin
            flags.rst_fail <= 1'b1;
            state          <= S_DONE;
          end else begin
            tries <= tries + 1'b1;
          end
        end
        S_AN_WR: if (acc_done) begin
          polls <= '0;
          state <= S_POLL_RD;
        end
        S_POLL_RD: if (acc_done) begin
          if (rd_link) begin
            flags.link_up <= 1'b1;
            state         <= S_DONE;
          end else if (polls == LAST_POLL) begin
            flags.timeout <= 1'b1;
            state         <= S_DONE;
          end else begin
            polls <= polls + 1'b1;
            state <= S_POLL_WAIT;
          end
        end
        S_POLL_WAIT: if (tmr_zero) state <= S_POLL_RD;
        S_DONE: if (start) begin
          flags    <= '0;
          phy_addr <= '0;
          state    <= S_HWRST;
        end
        default: state <= S_HWRST;
      endcase
    end
  end

  // the timer is armed for the reset pulse on restart and for the poll pause
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(POLL_GAP_CYCLES);
    if (state == S_DONE && start) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(RST_CYCLES);
    end else if (state == S_POLL_RD && acc_done && !rd_link && polls != LAST_POLL) begin
      tmr_load = 1'b1;
    end
  end

  always_comb begin
    is_access = 1'b0;
    we        = 1'b0;
    regn      = REG_CTRL;
    wdata     = '0;
    case (state)
      S_SCAN, S_SRST_RD: is_access = 1'b1;
      S_STAT, S_POLL_RD: begin
        is_access = 1'b1;
        regn      = REG_STAT;
      end
      S_SRST_WR: begin
        is_access = 1'b1;
        we        = 1'b1;
        wdata     = CMD_SRST;
      end
      S_AN_WR: begin
        is_access = 1'b1;
        we        = 1'b1;
        wdata     = CMD_AUTO;
      end
      default: is_access = 1'b0;
    endcase
  end

  assign req       = is_access && !gap;
  assign addr      = (state == S_SCAN) ? scan_addr : phy_addr;
  assign done      = (state == S_DONE);
  assign phy_rst_n = (state != S_HWRST);

endmodule

// File: rtl/phy_bringup.sv
module phy_bringup
  import phy_bringup_pkg::*;
#(
  parameter int RST_CYCLES      = 750000,
  parameter int POLL_GAP_CYCLES = 500000,
  parameter int POLL_LIMIT      = 500,
  parameter int RESET_TRIES     = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        phy_rst_n,
  output logic        mdio_req,
  output logic        mdio_we,
  output logic [4:0]  mdio_addr,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_done,
  input  logic [15:0] mdio_rdata,
  output logic [4:0]  phy_addr,
  output logic        done,
  output logic        link_up,
  output logic        err_no_phy,
  output logic        err_reset,
  output logic        warn_link_timeout
);

  localparam int ADDR_W  = 5;
  localparam int TMR_MAX = (RST_CYCLES > POLL_GAP_CYCLES) ? RST_CYCLES : POLL_GAP_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  bring_flags_t     flags;

  phy_bringup_timer #(
    .W    (TMR_W),
    .INIT (TMR_W'(RST_CYCLES))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  phy_bringup_ctrl #(
    .ADDR_W          (ADDR_W),
    .TMR_W           (TMR_W),
    .RST_CYCLES      (RST_CYCLES),
    .POLL_GAP_CYCLES (POLL_GAP_CYCLES),
    .POLL_LIMIT      (POLL_LIMIT),
    .RESET_TRIES     (RESET_TRIES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .req       (mdio_req),
    .we        (mdio_we),
    .addr      (mdio_addr),
    .regn      (mdio_reg),
    .wdata     (mdio_wdata),
    .acc_done  (mdio_done),
    .rdata     (mdio_rdata),
    .phy_rst_n (phy_rst_n),
    .phy_addr  (phy_addr),
    .done      (done),
    .flags     (flags)
  );

  assign link_up           = flags.link_up;
  assign err_no_phy        = flags.no_phy;
  assign err_reset         = flags.rst_fail;
  assign warn_link_timeout = flags.timeout;

endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
  parameter int RST_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        phy_rst_n,
  input logic        mdio_req,
  input logic        mdio_we,
  input logic [4:0]  mdio_addr,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        mdio_done,
  input logic        done,
  input logic        link_up,
  input logic        err_no_phy,
  input logic        err_reset,
  input logic        warn_link_timeout
);

  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (!phy_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  p_hwrst_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> low_cnt >= RST_CYCLES);

  p_no_req_in_hwrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_n |-> !mdio_req);

  p_write_vals_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_we) |-> (mdio_reg == 5'd0 &&
      (mdio_wdata == 16'h8000 || mdio_wdata == 16'h1300)));

  p_gap_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_done |=> !mdio_req);

  p_fields_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_we) && $stable(mdio_addr)
      && $stable(mdio_reg) && $stable(mdio_wdata)));

  p_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({link_up, err_no_phy, err_reset, warn_link_timeout}) == 1);

  p_no_flag_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $countones({link_up, err_no_phy, err_reset, warn_link_timeout}) == 0);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && !phy_rst_n));

endmodule

bind phy_bringup phy_bringup_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .start             (start),
  .phy_rst_n         (phy_rst_n),
  .mdio_req          (mdio_req),
  .mdio_we           (mdio_we),
  .mdio_addr         (mdio_addr),
  .mdio_reg          (mdio_reg),
  .mdio_wdata        (mdio_wdata),
  .mdio_done         (mdio_done),
  .done              (done),
  .link_up           (link_up),
  .err_no_phy        (err_no_phy),
  .err_reset         (err_reset),
  .warn_link_timeout (warn_link_timeout)
);

// File: tb/phy_bringup_tb_top.sv
`timescale 1ns/1ps
module phy_bringup_tb_top;

  localparam int RSTC  = 8;
  localparam int GAP   = 4;
  localparam int LIM   = 5;
  localparam int TRIES = 10;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        phy_rst_n, mdio_req, mdio_we;
  logic [4:0]  mdio_addr, mdio_reg, phy_addr;
  logic [15:0] mdio_wdata;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_rdata = '0;
  logic        done, link_up, err_no_phy, err_reset, warn_link_timeout;

  phy_bringup #(
    .RST_CYCLES(RSTC), .POLL_GAP_CYCLES(GAP), .POLL_LIMIT(LIM), .RESET_TRIES(TRIES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_rst_n(phy_rst_n),
    .mdio_req(mdio_req), .mdio_we(mdio_we), .mdio_addr(mdio_addr), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .phy_addr(phy_addr), .done(done), .link_up(link_up), .err_no_phy(err_no_phy),
    .err_reset(err_reset), .warn_link_timeout(warn_link_timeout)
  );

  always #2.5 clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  // responder model
  int m_phy, m_link_init, m_busy, m_link_after;
  int m_busy_left, m_an, m_srst, m_poll_n, m_located, scan_next;
  // trace log
  int n_acc, n_scan, scan_bad, n_stat, n_srst_wr, n_srst_rd, n_an_wr, n_poll;
  int wrong_addr, bad_write, min_gap, fields_changed, low_cnt, req_in_rst, last_done;
  // responder state
  int busy = 0, lat = 0, start_cyc = 0;
  logic        c_we;
  logic [4:0]  c_addr, c_reg;
  logic [15:0] c_wd;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_model(input int phy, input int li, input int bz, input int la);
    m_phy = phy; m_link_init = li; m_busy = bz; m_link_after = la;
    m_busy_left = 0; m_an = 0; m_srst = 0; m_poll_n = 0; m_located = 0; scan_next = 0;
    n_acc = 0; n_scan = 0; scan_bad = 0; n_stat = 0; n_srst_wr = 0; n_srst_rd = 0;
    n_an_wr = 0; n_poll = 0; wrong_addr = 0; bad_write = 0; min_gap = 1000000;
    fields_changed = 0; low_cnt = 0; req_in_rst = 0; last_done = 0;
  endtask

  function automatic logic [15:0] serve();
    logic [15:0] rd;
    rd = 16'h0000;
    n_acc++;
    if (m_located == 0) begin
      if (c_we || c_reg != 5'd0 || int'(c_addr) != scan_next) scan_bad++;
      n_scan++;
      scan_next++;
      if (int'(c_addr) == m_phy) begin
        m_located = 1;
        rd = 16'h1140;
      end else begin
        rd = 16'hFFFF;
      end
    end else begin
      if (int'(c_addr) != m_phy) wrong_addr++;
      if (c_we) begin
        if (c_reg == 5'd0 && c_wd == 16'h8000) begin
          n_srst_wr++; m_busy_left = m_busy; m_srst = 1;
        end else if (c_reg == 5'd0 && c_wd == 16'h1300) begin
          n_an_wr++;
          if (m_busy_left != 0 || m_srst == 0) bad_write++;
          m_an = 1;
        end else begin
          bad_write++;
        end
      end else if (c_reg == 5'd0) begin
        n_srst_rd++;
        if (m_busy_left > 0) begin
          m_busy_left--;
          rd = 16'h8000;
        end else begin
          rd = 16'h1140;
        end
      end else if (c_reg == 5'd1) begin
        if (m_an != 0) begin
          n_poll++;
          if (n_poll > 1 && (start_cyc - last_done) < min_gap) min_gap = start_cyc - last_done;
          m_poll_n++;
          rd = (m_poll_n >= m_link_after) ? 16'h782D : 16'h7809;
          last_done = cyc;
        end else begin
          n_stat++;
          rd = (m_link_init != 0) ? 16'h782D : 16'h7809;
        end
      end else begin
        bad_write++;
      end
    end
    return rd;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // responder and monitor, acting on falling edges only
  initial forever begin
    @(negedge clk);
    if (rst_n && !phy_rst_n) low_cnt++;
    if (!phy_rst_n && mdio_req) req_in_rst++;
    if (mdio_done) begin
      mdio_done = 1'b0;
    end else if (busy != 0) begin
      if (mdio_we != c_we || mdio_addr != c_addr || mdio_reg != c_reg || mdio_wdata != c_wd || !mdio_req)
        fields_changed++;
      if (lat == 0) begin
        mdio_rdata = serve();
        mdio_done  = 1'b1;
        busy = 0;
      end else begin
        lat--;
      end
    end else if (mdio_req) begin
      busy = 1; lat = LAT; start_cyc = cyc;
      c_we = mdio_we; c_addr = mdio_addr; c_reg = mdio_reg; c_wd = mdio_wdata;
    end
  end

  task automatic wait_done();
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check("R9 done reached", int'(done), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_case(input int phy, input int li, input int bz, input int la);
    set_model(phy, li, bz, la);
    pulse_start();
    wait_done();
  endtask

  task automatic common_checks();
    check("R8 fields stable", fields_changed, 0);
    check("R8 post-scan address", wrong_addr, 0);
    check("R1 no access in reset", req_in_rst, 0);
    check("R6 write legal", bad_write, 0);
    check("R9 one flag", int'(link_up) + int'(err_no_phy) + int'(err_reset) + int'(warn_link_timeout), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    set_model(5, 1, 0, 1);
    repeat (3) @(negedge clk);
    check("R10 done", int'(done), 0);
    check("R10 flags", int'({link_up, err_no_phy, err_reset, warn_link_timeout}), 0);
    check("R10 phy_rst_n", int'(phy_rst_n), 0);
    check("R10 req", int'(mdio_req), 0);
    check("R10 phy_addr", int'(phy_addr), 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    low_cnt = 0;
    wait_done();
    check("R1 power-up reset length", low_cnt, RSTC);
    check("R4 power-up link", int'(link_up), 1);
    check("R2 power-up addr", int'(phy_addr), 5);
    repeat (10) @(negedge clk);
    check("R9 done holds", int'(done), 1);
    check("R9 flag holds", int'(link_up), 1);

    // R2 R4: PHY at every address, link already up
    for (int a = 0; a < 32; a++) begin
      run_case(a, 1, 0, 1);
      check("R1 restart reset length", low_cnt, RSTC + 1);
      check("R2 found address", int'(phy_addr), a);
      check("R2 scan reads", n_scan, a + 1);
      check("R2 scan order", scan_bad, 0);
      check("R4 link_up", int'(link_up), 1);
      check("R4 status reads", n_stat, 1);
      check("R4 no writes", n_srst_wr + n_an_wr, 0);
      common_checks();
    end

    // R3: no PHY answers
    run_case(32, 1, 0, 1);
    check("R3 err_no_phy", int'(err_no_phy), 1);
    check("R3 accesses", n_acc, 32);
    check("R3 scan order", scan_bad, 0);
    check("R3 phy_rst_n released", int'(phy_rst_n), 1);
    common_checks();

    // R5 R6: soft reset busy for bz reads
    for (int bz = 0; bz <= TRIES; bz++) begin
      run_case(9, 0, bz, 1);
      check("R5 soft reset write", n_srst_wr, 1);
      if (bz < TRIES) begin
        check("R5 soft reset reads", n_srst_rd, bz + 1);
        check("R6 auto-neg write", n_an_wr, 1);
        check("R7 link_up after 1 poll", int'(link_up), 1);
        check("R7 poll count", n_poll, 1);
      end else begin
        check("R5 err_reset", int'(err_reset), 1);
        check("R5 soft reset reads at limit", n_srst_rd, TRIES);
        check("R5 no auto-neg write", n_an_wr, 0);
        check("R5 no polls", n_poll, 0);
      end
      common_checks();
    end

    // R7: link comes up after la polls
    for (int la = 1; la <= LIM + 1; la++) begin
      run_case(3, 0, 2, la);
      if (la <= LIM) begin
        check("R7 link_up", int'(link_up), 1);
        check("R7 polls", n_poll, la);
      end else begin
        check("R7 warn_link_timeout", int'(warn_link_timeout), 1);
        check("R7 polls at limit", n_poll, LIM);
      end
      if (la > 1) check("R7 poll gap respected", int'(min_gap >= GAP), 1);
      common_checks();
    end

    // R9: start while busy is ignored
    set_model(20, 1, 0, 1);
    pulse_start();
    while (n_scan < 5) @(negedge clk);
    pulse_start();
    wait_done();
    check("R9 busy start ignored scan", n_scan, 21);
    check("R9 busy start no second reset", low_cnt, RSTC + 1);
    check("R9 busy start addr", int'(phy_addr), 20);
    check("R9 busy start link", int'(link_up), 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule